// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the status-register write path inside a serial flash slave. It watches the chip-select, serial clock and serial data lines of an SPI mode 0/3 link. A frame opens when chip-select falls, and its first byte is an opcode. Either of two prefix opcodes arms a write-enable latch. A later write-status frame carries one or two data bytes, shifted most significant bit first, and these are committed when chip-select rises.

Whether a commit happens depends on four things: the exact number of data bits received, the state of the write-enable latch, the active-low write-protect pin, and the lock bit held in the first status register. While the pin is low and the lock bit is set, the registers are frozen. While the pin is high, software may change every writable bit, and that includes clearing the lock. Both registers are driven on output ports.

The serial lines are sampled with a fast system clock through a short synchroniser chain. Serial-clock edges are found by comparing successive samples. Chip-select high clears all framing state, so every frame decodes from its first bit.

Top module: `flash_status_writer`

## Requirements
- R1: After synchronous reset, both status registers and the write-enable latch read 0.
- R2: A frame of exactly 8 bits carrying opcode 0x06 or 0x50 sets the write-enable latch. A prefix opcode in a frame of any other length, or any other non-write opcode, leaves the latch as it was.
- R3: A write-status frame is opcode 0x01 followed by data bits. With exactly 8 data bits, the first register is loaded as follows: data bit 4:2 goes to the protect field at register bits 4:2, and data bit 7 goes to the lock at register bit 7. Register bits 6, 5, 1 and 0 read 0, and the quad-enable bit in the second register is cleared.
- R4: With exactly 16 data bits, the first data byte loads the first register as in R3. Bit 1 of the second data byte loads quad-enable at bit 1 of the second register. All other bits of the second register read 0.
- R5: A write-status frame whose data-bit count is neither 8 nor 16 changes neither register.
- R6: A write-status frame that arrives while the write-enable latch is clear changes neither register.
- R7: The write-enable latch is clear after any write-status frame whose opcode was fully received, whether or not that frame committed.
- R8: While write-protect is high at commit, every writable bit may change, including the lock going from 1 to 0.
- R9: While write-protect is low and the lock is 0, a write commits. A single write may set the lock and change the protect field together.
- R10: While write-protect is low and the lock is 1, a write-status frame leaves both registers unchanged, so the lock cannot return to 0.
- R11: Raising chip-select in the middle of a frame discards its bits, and the next frame decodes from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| csn_i | input | 1 | Active-low chip-select |
| sck_i | input | 1 | Serial clock, mode 0/3 |
| sdi_i | input | 1 | Serial data in, sampled on rising serial clock |
| wp_n_i | input | 1 | Active-low write-protect pin |
| sr1_o | output | 8 | First status register (lock bit 7, protect bits 4:2) |
| sr2_o | output | 8 | Second status register (quad-enable bit 1) |
| wel_o | output | 1 | Write-enable latch |

## Verification
The bench sweeps every value of the first data byte. For each value it alternates the one-byte and two-byte forms, varies the write-protect pin, and now and then skips the prefix. This drives the lock through every combination of pin and lock state. A design that ignored the interlock would release a locked register, and one that gated on the wrong polarity would refuse writes that are legal. A design that forgot to clear quad-enable on a one-byte write would show a stale bit. Dedicated frames cover the remaining cases: a prefix one bit too long, data counts of 12 bits, a write with the latch clear, and a frame aborted mid-opcode. Mistakes in the counter's exact-length test or in its reset on chip-select would commit or refuse the wrong frames, or misalign the next opcode.

// File: rtl/flash_sr_pkg.sv
// Shared constants for the status-register write path.
// Assumes byte-wide opcodes and registers; bit positions are fixed by the register map.
package flash_sr_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_WREN_A = 8'h06;
    localparam logic [BYTE_W-1:0] OPC_WREN_B = 8'h50;
    localparam logic [BYTE_W-1:0] OPC_WRSR   = 8'h01;

    // Writable bits of each register: lock 7, protect 4:2 / quad-enable 1.
    localparam logic [BYTE_W-1:0] SR1_WMASK = 8'b1001_1100;
    localparam logic [BYTE_W-1:0] SR2_WMASK = 8'b0000_0010;
    localparam int SR1_LOCK_BIT = 7;
endpackage

// File: rtl/sr_in_sync.sv
// Samples the serial lines into the system clock domain and finds serial-clock
// and chip-select rising edges. Assumes clk is several times faster than sck.
module sr_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic sdi_i,
    output logic sck_rise_o,
    output logic csn_rise_o,
    output logic csn_high_o,
    output logic sdi_o
);
    logic [STAGES:0]   sck_pipe;
    logic [STAGES:0]   csn_pipe;
    logic [STAGES-1:0] sdi_pipe;

    // Shift each line through its chain; chip-select idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            csn_pipe <= '1;
            sdi_pipe <= '0;
        end else begin
            for (int i = STAGES; i > 0; i--) begin
                sck_pipe[i] <= sck_pipe[i-1];
                csn_pipe[i] <= csn_pipe[i-1];
            end
            for (int i = STAGES - 1; i > 0; i--) begin
                sdi_pipe[i] <= sdi_pipe[i-1];
            end
            sck_pipe[0] <= sck_i;
            csn_pipe[0] <= csn_i;
            sdi_pipe[0] <= sdi_i;
        end
    end

    // Edge flags compare the last synchronised sample with the one before.
    assign sck_rise_o = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
    assign csn_rise_o = csn_pipe[STAGES-1] & ~csn_pipe[STAGES];
    assign csn_high_o = csn_pipe[STAGES-1];
    assign sdi_o      = sdi_pipe[STAGES-1];
endmodule

// File: rtl/sr_frame_rx.sv
// Counts serial bits of a frame, captures the opcode byte and keeps the last
// two data bytes in a shift register. Assumes framing is reset while csn is high.
module sr_frame_rx #(
    parameter int BYTE_W      = 8,
    parameter int DATA_BYTES  = 2,
    localparam int DATA_BITS  = BYTE_W * DATA_BYTES,
    localparam int CNT_MAX    = BYTE_W + DATA_BITS + 1,
    localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csn_high_i,
    input  logic                 sck_rise_i,
    input  logic                 sdi_i,
    output logic [CNT_W-1:0]     bit_cnt_o,
    output logic [BYTE_W-1:0]    opcode_o,
    output logic [DATA_BITS-1:0] shreg_o
);
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_W-1:0]    opc_q;
    logic [DATA_BITS-1:0] sh_q;

    // Shift data and count bits on each serial-clock rise within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || csn_high_i) begin
            cnt_q <= '0;
            sh_q  <= '0;
            if (!rst_n) opc_q <= '0;
        end else if (sck_rise_i) begin
            sh_q <= {sh_q[DATA_BITS-2:0], sdi_i};
            if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(BYTE_W - 1)) opc_q <= {sh_q[BYTE_W-2:0], sdi_i};
        end
    end

    assign bit_cnt_o = cnt_q;
    assign opcode_o  = opc_q;
    assign shreg_o   = sh_q;

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: rtl/sr_cmd_decode.sv
// Classifies a frame at the chip-select rising edge: prefix complete, write-status
// attempt, and its one- or two-byte form. Assumes opcode is valid once 8 bits are in.
module sr_cmd_decode
    import flash_sr_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int DATA_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csn_rise_i,
    input  logic [CNT_W-1:0]     bit_cnt_i,
    input  logic [BYTE_W-1:0]    opcode_i,
    input  logic [DATA_BITS-1:0] shreg_i,
    output logic                 prefix_done_o,
    output logic                 wrsr_try_o,
    output logic                 wrsr_one_o,
    output logic                 wrsr_two_o,
    output logic [BYTE_W-1:0]    byte_a_o,
    output logic [BYTE_W-1:0]    byte_b_o
);
    logic opc_full;
    logic is_prefix;

    // Decode opcode class and exact data length at the end of the frame.
    always_comb begin
        opc_full      = bit_cnt_i >= CNT_W'(BYTE_W);
        is_prefix     = (opcode_i == OPC_WREN_A) || (opcode_i == OPC_WREN_B);
        prefix_done_o = csn_rise_i && is_prefix && (bit_cnt_i == CNT_W'(BYTE_W));
        wrsr_try_o    = csn_rise_i && opc_full && (opcode_i == OPC_WRSR);
        wrsr_one_o    = wrsr_try_o && (bit_cnt_i == CNT_W'(2 * BYTE_W));
        wrsr_two_o    = wrsr_try_o && (bit_cnt_i == CNT_W'(3 * BYTE_W));
    end

    // Pick the first data byte from the window that matches the frame length.
    always_comb begin
        if (wrsr_two_o) byte_a_o = shreg_i[DATA_BITS-1 -: BYTE_W];
        else            byte_a_o = shreg_i[BYTE_W-1:0];
        byte_b_o = shreg_i[BYTE_W-1:0];
    end

    // R2
    frame_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prefix_done_o, wrsr_one_o, wrsr_two_o}));
endmodule

// File: rtl/sr_status_bank.sv
// Holds the write-enable latch and both status registers, applying the
// write-protect pin and lock interlock at commit. Assumes decode pulses last one cycle.
module sr_status_bank
    import flash_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              prefix_done_i,
    input  logic              wrsr_try_i,
    input  logic              wrsr_one_i,
    input  logic              wrsr_two_i,
    input  logic [BYTE_W-1:0] byte_a_i,
    input  logic [BYTE_W-1:0] byte_b_i,
    output logic [BYTE_W-1:0] sr1_o,
    output logic [BYTE_W-1:0] sr2_o,
    output logic              wel_o
);
    logic [BYTE_W-1:0] sr1_q;
    logic [BYTE_W-1:0] sr2_q;
    logic              wel_q;
    logic              frozen;
    logic              commit;

    // Commit needs the latch, an exact length and no pin-plus-lock freeze.
    always_comb begin
        frozen = !wp_n_i && sr1_q[SR1_LOCK_BIT];
        commit = wrsr_try_i && wel_q && (wrsr_one_i || wrsr_two_i) && !frozen;
    end

    // Write-enable latch: armed by a prefix, dropped by any write-status attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)             wel_q <= 1'b0;
        else if (prefix_done_i) wel_q <= 1'b1;
        else if (wrsr_try_i)    wel_q <= 1'b0;
    end

    // Status registers: load masked data; one-byte form clears the second register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr1_q <= '0;
            sr2_q <= '0;
        end else if (commit) begin
            sr1_q <= byte_a_i & SR1_WMASK;
            sr2_q <= wrsr_two_i ? (byte_b_i & SR2_WMASK) : '0;
        end
    end

    assign sr1_o = sr1_q;
    assign sr2_o = sr2_q;
    assign wel_o = wel_q;

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_try_i && !wp_n_i && sr1_q[SR1_LOCK_BIT]) |=> $stable({sr1_q, sr2_q}));
    // R6
    no_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_try_i && !wel_q) |=> $stable({sr1_q, sr2_q}));
    // R7
    latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_try_i |=> !wel_q);
    // R5
    bad_len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_try_i && !wrsr_one_i && !wrsr_two_i) |=> $stable({sr1_q, sr2_q}));
endmodule

// File: rtl/flash_status_writer.sv
// Top of the status-register write path: synchroniser, frame receiver,
// command decoder and register bank. Assumes inputs are free of glitches.
module flash_status_writer #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              wp_n_i,
    output logic [BYTE_W-1:0] sr1_o,
    output logic [BYTE_W-1:0] sr2_o,
    output logic              wel_o
);
    localparam int DATA_BITS = 2 * BYTE_W;
    localparam int CNT_W     = $clog2(BYTE_W + DATA_BITS + 2);

    logic                 sck_rise, csn_rise, csn_high, sdi_s;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_W-1:0]    opcode;
    logic [DATA_BITS-1:0] shreg;
    logic                 prefix_done, wrsr_try, wrsr_one, wrsr_two;
    logic [BYTE_W-1:0]    byte_a, byte_b;

    sr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_i),
        .csn_i      (csn_i),
        .sdi_i      (sdi_i),
        .sck_rise_o (sck_rise),
        .csn_rise_o (csn_rise),
        .csn_high_o (csn_high),
        .sdi_o      (sdi_s)
    );

    sr_frame_rx #(.BYTE_W(BYTE_W), .DATA_BYTES(2)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn_high_i (csn_high),
        .sck_rise_i (sck_rise),
        .sdi_i      (sdi_s),
        .bit_cnt_o  (bit_cnt),
        .opcode_o   (opcode),
        .shreg_o    (shreg)
    );

    sr_cmd_decode #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .csn_rise_i    (csn_rise),
        .bit_cnt_i     (bit_cnt),
        .opcode_i      (opcode),
        .shreg_i       (shreg),
        .prefix_done_o (prefix_done),
        .wrsr_try_o    (wrsr_try),
        .wrsr_one_o    (wrsr_one),
        .wrsr_two_o    (wrsr_two),
        .byte_a_o      (byte_a),
        .byte_b_o      (byte_b)
    );

    sr_status_bank u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .wp_n_i        (wp_n_i),
        .prefix_done_i (prefix_done),
        .wrsr_try_i    (wrsr_try),
        .wrsr_one_i    (wrsr_one),
        .wrsr_two_i    (wrsr_two),
        .byte_a_i      (byte_a),
        .byte_b_i      (byte_b),
        .sr1_o         (sr1_o),
        .sr2_o         (sr2_o),
        .wel_o         (wel_o)
    );
endmodule

// File: tb/flash_status_writer_test.sv
module flash_status_writer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, wp_n = 1'b1;
    logic [7:0] sr1, sr2;
    logic       wel;

    always #2 clk = ~clk;

    flash_status_writer uut (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
        .wp_n_i(wp_n), .sr1_o(sr1), .sr2_o(sr2), .wel_o(wel)
    );

    int total = 0;
    int bad = 0;
    logic [7:0] e_sr1 = 8'h00, e_sr2 = 8'h00;
    logic       e_wel = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag);
        total++;
        if ({sr1, sr2, wel} !== {e_sr1, e_sr2, e_wel}) begin
            bad++;
            $display("FAIL %s sr1/sr2/wel actual=%h/%h/%b expected=%h/%h/%b",
                     tag, sr1, sr2, wel, e_sr1, e_sr2, e_wel);
        end
    endtask

    // Drive nb bits of a 24-bit frame MSB first, then raise chip-select.
    task automatic send(input logic [23:0] fr, input int nb);
        csn = 1'b0;
        tick(2);
        for (int i = 0; i < nb; i++) begin
            sdi = fr[23-i];
            tick(2);
            sck = 1'b1;
            tick(2);
            sck = 1'b0;
        end
        tick(2);
        csn = 1'b1;
        tick(8);
    endtask

    // Reference model of the requirements.
    task automatic model(input logic [7:0] op, input logic [7:0] b1,
                         input logic [7:0] b2, input int nb);
        if (nb == 8 && (op == 8'h06 || op == 8'h50)) e_wel = 1'b1;
        if (op == 8'h01 && nb >= 8) begin
            if (e_wel && (nb == 16 || nb == 24) && !(!wp_n && e_sr1[7])) begin
                e_sr1 = b1 & 8'h9C;
                e_sr2 = (nb == 24) ? (b2 & 8'h02) : 8'h00;
            end
            e_wel = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] op, input logic [7:0] b1,
                         input logic [7:0] b2, input int nb, input string tag);
        send({op, b1, b2}, nb);
        model(op, b1, b2, nb);
        check(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        string tg;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R1");

        // R2: prefix variants
        frame(8'h06, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'h9C, 8'h02, 24, "R4");
        frame(8'h50, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'hFF, 8'hFF, 16, "R3");
        frame(8'h06, 8'h00, 8'h00, 9, "R2");
        frame(8'h04, 8'h00, 8'h00, 8, "R2");
        // R7 / R5: odd length drops latch, keeps registers
        wp_n = 1'b1;
        frame(8'h06, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'h00, 8'h00, 20, "R5");
        frame(8'h01, 8'h00, 8'h00, 16, "R6");
        // R8: pin high lets lock fall
        frame(8'h06, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'h10, 8'h02, 24, "R8");
        // R9: pin low, lock 0, set lock and protect together
        wp_n = 1'b0;
        frame(8'h06, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'h8C, 8'h02, 24, "R9");
        // R10: pin low, lock 1, frozen
        frame(8'h06, 8'h00, 8'h00, 8, "R2");
        frame(8'h01, 8'h00, 8'h00, 24, "R10");
        frame(8'h01, 8'h00, 8'h00, 12, "R7");
        // R11: abort mid-opcode then clean prefix
        wp_n = 1'b1;
        send(24'hFF_FFFF, 5);
        check("R11");
        frame(8'h06, 8'h00, 8'h00, 8, "R11");
        frame(8'h01, 8'h00, 8'h00, 16, "R3");

        // Sweep every first-byte value across forms and pin states.
        for (int k = 0; k < 256; k++) begin
            d = k[7:0];
            wp_n = d[0] ^ d[5];
            if ((k % 7) != 0) frame(8'h06, 8'h00, 8'h00, 8, "R2");
            if (!e_wel)                 tg = "R6";
            else if (!wp_n && e_sr1[7]) tg = "R10";
            else if (wp_n)              tg = "R8";
            else                        tg = "R9";
            frame(8'h01, d, ~d, d[1] ? 24 : 16, tg);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule